// File: doc/BRIEF.md
# Auto-Increment Indirect Access Window

This block lets a host reach internal memory and internal peripheral registers through a small set of host-visible registers, without mapping those resources directly. A memory access takes two steps. The host first loads an address register. It then reads or writes a data register. Reads and writes each keep their own pointer. Every access to a memory data register moves that pointer forward by one 32-bit word, so a block transfer needs only one address write followed by repeated data accesses.

Loading the read pointer starts a prefetch. The first read of the read-data register therefore returns the word at the new address at once. Each later read hands back the buffered word and starts fetching the next one. A second pair of registers gives access to peripheral registers. It takes a 16-bit offset and a 2-bit count that holds the access size in bytes minus one. Peripheral accesses never move their offset.

All traffic to internal resources depends on a wake-status input. While that input is low, data-register reads return a fixed idle pattern, data-register writes are discarded, and a sticky error flag is set. Internally, all memory and peripheral traffic shares one request port. Read data arrives on that port one cycle after the request.

Top module: `iaw_window`

## Requirements
- R1: After reset, `host_ready_o` is 1, `host_rvalid_o` and `int_req_o` are 0, and both the status register (index 8) and the memory read-address register (index 0) read as 0.
- R2: Writing index 0 while awake issues an internal memory read at the written byte address in the next cycle. The next read of index 1 returns that word. If index 0 was written while asleep, the first read of index 1 after waking fetches the word on demand.
- R3: Each served read of index 1 advances the read pointer by 4, so successive reads return successive words. Index 0 reads back the current pointer.
- R4: Index 2 holds the write pointer and index 3 is the write-data register. A write to index 3 stores the word at the write pointer with all four byte enables set, then advances the pointer by 4. The read and write pointers do not affect each other.
- R5: The peripheral address registers (read at index 4, write at index 6) keep an offset in bits 15:0 and a count in bits 25:24. They read back in that layout with all other bits 0. A peripheral access drives `int_prph_o` high with the offset as its address and does not change the offset.
- R6: A write to index 7 with count c enables byte lanes 0 to c only (`int_be_o` = 2^(c+1)-1), so the upper bytes of the target register are left unchanged.
- R7: A read of index 5 with count c returns the low c+1 bytes of the peripheral register, with the upper bytes 0.
- R8: While `wake_i` is low, a read of index 1 or 5 answers in the next cycle with 0xA5A5A5A5, issues no internal request and does not move the read pointer.
- R9: While `wake_i` is low, writes to index 3 or 7 issue no internal request and do not move the write pointer. Such writes, and asleep data reads, set status bit 0. That bit stays set until the host writes 1 to bit 0 of index 8.
- R10: While an internal read is outstanding, `host_ready_o` is low. A read of any register other than a fetching data read answers in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_i | input | 1 | Internal domain awake status |
| host_req_i | input | 1 | Host register access request |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_reg_i | input | 4 | Host register index |
| host_wdata_i | input | 32 | Host write data |
| host_ready_o | output | 1 | Block can accept a host access |
| host_rvalid_o | output | 1 | Host read response valid |
| host_rdata_o | output | 32 | Host read response data |
| int_req_o | output | 1 | Internal access request |
| int_we_o | output | 1 | Internal write (1) or read (0) |
| int_prph_o | output | 1 | Target is the peripheral space (1) or memory (0) |
| int_addr_o | output | 32 | Internal byte address or peripheral offset |
| int_be_o | output | 4 | Internal byte enables |
| int_wdata_o | output | 32 | Internal write data |
| int_rdata_i | input | 32 | Internal read data, valid one cycle after a read request |

## Verification
The assertions assume that the host raises a request only while `host_ready_o` is high. They also assume that internal read data returns exactly one cycle after the request. Given those two conditions, the properties check that an idle pattern is returned while asleep and that requests are suppressed then, and they cover the prefetch issue and the byte-enable shapes. The bench's host tasks wait for ready before every access, and they change `wake_i` only between accesses. Its memory model answers with a registered read, so both assumptions hold throughout the stimulus.

// File: rtl/iaw_pkg.sv
package iaw_pkg;

    // Register indices seen by the host
    localparam int unsigned REG_MRA  = 0;  // memory read pointer
    localparam int unsigned REG_MRD  = 1;  // memory read data
    localparam int unsigned REG_MWA  = 2;  // memory write pointer
    localparam int unsigned REG_MWD  = 3;  // memory write data
    localparam int unsigned REG_PRA  = 4;  // peripheral read offset/count
    localparam int unsigned REG_PRD  = 5;  // peripheral read data
    localparam int unsigned REG_PWA  = 6;  // peripheral write offset/count
    localparam int unsigned REG_PWD  = 7;  // peripheral write data
    localparam int unsigned REG_STS  = 8;  // sticky error status
    localparam int unsigned NUM_REGS = 9;

    // Which outstanding internal read is in flight
    typedef enum logic [1:0] {
        FK_NONE     = 2'd0,
        FK_PREFETCH = 2'd1,
        FK_MEM      = 2'd2,
        FK_PRPH     = 2'd3
    } fetch_kind_e;

endpackage

// File: rtl/iaw_reg_decode.sv
module iaw_reg_decode #(
    parameter int unsigned REG_AW = 4,
    parameter int unsigned NREG   = 9
) (
    input  logic              acc_i,
    input  logic              we_i,
    input  logic [REG_AW-1:0] idx_i,
    output logic [NREG-1:0]   wr_hit_o,
    output logic [NREG-1:0]   rd_hit_o
);

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        logic sel;
        assign sel         = (idx_i == REG_AW'(i));
        assign wr_hit_o[i] = acc_i && we_i && sel;
        assign rd_hit_o[i] = acc_i && !we_i && sel;
    end

endmodule

// File: rtl/iaw_lane_mask.sv
module iaw_lane_mask #(
    parameter int unsigned DW = 32,
    localparam int unsigned NB = DW / 8,
    localparam int unsigned CW = $clog2(NB)
) (
    input  logic [CW-1:0] cnt_i,
    input  logic [DW-1:0] din_i,
    output logic [NB-1:0] be_o,
    output logic [DW-1:0] dout_o
);

    // Lane g is active when the encoded size (bytes minus one) reaches it
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign be_o[g]          = ({1'b0, cnt_i} >= (CW + 1)'(g));
        assign dout_o[g*8 +: 8] = be_o[g] ? din_i[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/iaw_window.sv
module iaw_window
    import iaw_pkg::*;
#(
    parameter int unsigned   DW        = 32,
    parameter int unsigned   AW        = 32,
    parameter int unsigned   REG_AW    = 4,
    parameter int unsigned   OFF_W     = 16,
    parameter int unsigned   CNT_LSB   = 24,
    parameter logic [DW-1:0] IDLE_WORD = 32'hA5A5_A5A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_i,
    input  logic              host_req_i,
    input  logic              host_we_i,
    input  logic [REG_AW-1:0] host_reg_i,
    input  logic [DW-1:0]     host_wdata_i,
    output logic              host_ready_o,
    output logic              host_rvalid_o,
    output logic [DW-1:0]     host_rdata_o,
    output logic              int_req_o,
    output logic              int_we_o,
    output logic              int_prph_o,
    output logic [AW-1:0]     int_addr_o,
    output logic [DW/8-1:0]   int_be_o,
    output logic [DW-1:0]     int_wdata_o,
    input  logic [DW-1:0]     int_rdata_i
);

    localparam int unsigned NB   = DW / 8;
    localparam int unsigned CW   = $clog2(NB);
    localparam logic [AW-1:0] STEP = AW'(NB);

    typedef struct packed {
        logic [AW-1:0]    rd_ptr;
        logic [AW-1:0]    wr_ptr;
        logic [DW-1:0]    pbuf;
        logic             pbuf_vld;
        logic [OFF_W-1:0] prd_off;
        logic [CW-1:0]    prd_cnt;
        logic [OFF_W-1:0] pwr_off;
        logic [CW-1:0]    pwr_cnt;
        logic             err;
        logic             req;
        logic             we;
        logic             prph;
        logic [AW-1:0]    addr;
        logic [NB-1:0]    be;
        logic [DW-1:0]    wdata;
        fetch_kind_e      iss;
        fetch_kind_e      cap;
        logic             rvalid;
        logic [DW-1:0]    rdata;
    } st_t;

    st_t st_d, st_q;

    logic                busy;
    logic                acc;
    logic [NUM_REGS-1:0] wr_hit;
    logic [NUM_REGS-1:0] rd_hit;
    logic [NB-1:0]       rd_be;
    logic [DW-1:0]       rd_masked;
    logic [NB-1:0]       wr_be;
    logic [DW-1:0]       wr_masked;

    assign busy = (st_q.iss != FK_NONE) || (st_q.cap != FK_NONE);
    assign acc  = host_req_i && !busy;

    iaw_reg_decode #(
        .REG_AW (REG_AW),
        .NREG   (NUM_REGS)
    ) u_decode (
        .acc_i    (acc),
        .we_i     (host_we_i),
        .idx_i    (host_reg_i),
        .wr_hit_o (wr_hit),
        .rd_hit_o (rd_hit)
    );

    // Read path: lanes from the read count mask returned peripheral data
    iaw_lane_mask #(.DW(DW)) u_rd_lanes (
        .cnt_i  (st_q.prd_cnt),
        .din_i  (int_rdata_i),
        .be_o   (rd_be),
        .dout_o (rd_masked)
    );

    // Write path: lanes from the write count gate host data
    iaw_lane_mask #(.DW(DW)) u_wr_lanes (
        .cnt_i  (st_q.pwr_cnt),
        .din_i  (host_wdata_i),
        .be_o   (wr_be),
        .dout_o (wr_masked)
    );

    function automatic logic [DW-1:0] pack_prph(input logic [OFF_W-1:0] off,
                                                input logic [CW-1:0]    cnt);
        logic [DW-1:0] v;
        v                   = '0;
        v[OFF_W-1:0]        = off;
        v[CNT_LSB +: CW]    = cnt;
        return v;
    endfunction

    always_comb begin
        st_d        = st_q;
        st_d.req    = 1'b0;
        st_d.we     = 1'b0;
        st_d.prph   = 1'b0;
        st_d.rvalid = 1'b0;
        st_d.iss    = FK_NONE;
        st_d.cap    = st_q.iss;

        // Capture data of the read issued two edges ago
        case (st_q.cap)
            FK_PREFETCH: begin
                st_d.pbuf     = int_rdata_i;
                st_d.pbuf_vld = 1'b1;
            end
            FK_MEM: begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = int_rdata_i;
                st_d.rd_ptr = st_q.rd_ptr + STEP;
            end
            FK_PRPH: begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = rd_masked;
            end
            default: ;
        endcase

        // Memory read pointer
        if (wr_hit[REG_MRA]) begin
            st_d.rd_ptr   = host_wdata_i[AW-1:0];
            st_d.pbuf_vld = 1'b0;
            if (wake_i) begin
                st_d.req  = 1'b1;
                st_d.addr = host_wdata_i[AW-1:0];
                st_d.be   = '1;
                st_d.iss  = FK_PREFETCH;
            end
        end
        if (rd_hit[REG_MRA]) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = DW'(st_q.rd_ptr);
        end

        // Memory read data
        if (rd_hit[REG_MRD]) begin
            if (!wake_i) begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = IDLE_WORD;
                st_d.err    = 1'b1;
            end else if (st_q.pbuf_vld) begin
                st_d.rvalid   = 1'b1;
                st_d.rdata    = st_q.pbuf;
                st_d.rd_ptr   = st_q.rd_ptr + STEP;
                st_d.pbuf_vld = 1'b0;
                st_d.req      = 1'b1;
                st_d.addr     = st_q.rd_ptr + STEP;
                st_d.be       = '1;
                st_d.iss      = FK_PREFETCH;
            end else begin
                st_d.req  = 1'b1;
                st_d.addr = st_q.rd_ptr;
                st_d.be   = '1;
                st_d.iss  = FK_MEM;
            end
        end

        // Memory write pointer and data
        if (wr_hit[REG_MWA]) begin
            st_d.wr_ptr = host_wdata_i[AW-1:0];
        end
        if (rd_hit[REG_MWA]) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = DW'(st_q.wr_ptr);
        end
        if (wr_hit[REG_MWD]) begin
            if (wake_i) begin
                st_d.req    = 1'b1;
                st_d.we     = 1'b1;
                st_d.addr   = st_q.wr_ptr;
                st_d.be     = '1;
                st_d.wdata  = host_wdata_i;
                st_d.wr_ptr = st_q.wr_ptr + STEP;
            end else begin
                st_d.err = 1'b1;
            end
        end
        if (rd_hit[REG_MWD] || rd_hit[REG_PWD]) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = '0;
        end

        // Peripheral offset/count registers
        if (wr_hit[REG_PRA]) begin
            st_d.prd_off = host_wdata_i[OFF_W-1:0];
            st_d.prd_cnt = host_wdata_i[CNT_LSB +: CW];
        end
        if (rd_hit[REG_PRA]) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = pack_prph(st_q.prd_off, st_q.prd_cnt);
        end
        if (wr_hit[REG_PWA]) begin
            st_d.pwr_off = host_wdata_i[OFF_W-1:0];
            st_d.pwr_cnt = host_wdata_i[CNT_LSB +: CW];
        end
        if (rd_hit[REG_PWA]) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = pack_prph(st_q.pwr_off, st_q.pwr_cnt);
        end

        // Peripheral data registers: no offset advance
        if (rd_hit[REG_PRD]) begin
            if (wake_i) begin
                st_d.req  = 1'b1;
                st_d.prph = 1'b1;
                st_d.addr = AW'(st_q.prd_off);
                st_d.be   = rd_be;
                st_d.iss  = FK_PRPH;
            end else begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = IDLE_WORD;
                st_d.err    = 1'b1;
            end
        end
        if (wr_hit[REG_PWD]) begin
            if (wake_i) begin
                st_d.req   = 1'b1;
                st_d.we    = 1'b1;
                st_d.prph  = 1'b1;
                st_d.addr  = AW'(st_q.pwr_off);
                st_d.be    = wr_be;
                st_d.wdata = wr_masked;
            end else begin
                st_d.err = 1'b1;
            end
        end

        // Sticky status, write one to clear
        if (wr_hit[REG_STS] && host_wdata_i[0]) begin
            st_d.err = 1'b0;
        end
        if (rd_hit[REG_STS]) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = DW'(st_q.err);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_ready_o  = !busy;
    assign host_rvalid_o = st_q.rvalid;
    assign host_rdata_o  = st_q.rdata;
    assign int_req_o     = st_q.req;
    assign int_we_o      = st_q.we;
    assign int_prph_o    = st_q.prph;
    assign int_addr_o    = st_q.addr;
    assign int_be_o      = st_q.be;
    assign int_wdata_o   = st_q.wdata;

endmodule

// File: rtl/iaw_window_chk.sv
module iaw_window_chk #(
    parameter int unsigned   DW        = 32,
    parameter int unsigned   AW        = 32,
    parameter int unsigned   REG_AW    = 4,
    parameter logic [DW-1:0] IDLE_WORD = 32'hA5A5_A5A5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wake_i,
    input logic              host_req_i,
    input logic              host_we_i,
    input logic [REG_AW-1:0] host_reg_i,
    input logic [DW-1:0]     host_wdata_i,
    input logic              host_ready_o,
    input logic              host_rvalid_o,
    input logic [DW-1:0]     host_rdata_o,
    input logic              int_req_o,
    input logic              int_we_o,
    input logic              int_prph_o,
    input logic [AW-1:0]     int_addr_o,
    input logic [DW/8-1:0]   int_be_o
);

    logic acc;
    logic data_rd;
    logic [DW/8-1:0] be_plus;
    assign acc     = host_req_i && host_ready_o;
    assign data_rd = (host_reg_i == REG_AW'(1)) || (host_reg_i == REG_AW'(5));
    assign be_plus = int_be_o + 1'b1;

    // R2
    raddr_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && host_we_i && wake_i && (host_reg_i == REG_AW'(0))
        |=> int_req_o && !int_we_o && !int_prph_o && (int_addr_o == $past(host_wdata_i[AW-1:0])));

    // R4
    mem_wr_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req_o && int_we_o && !int_prph_o |-> (int_be_o == '1));

    // R6
    prph_be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req_o && int_prph_o |-> int_be_o[0] && ((int_be_o & be_plus) == '0));

    // R8
    sleep_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !host_we_i && !wake_i && data_rd
        |=> host_rvalid_o && (host_rdata_o == IDLE_WORD));

    // R9
    sleep_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !wake_i |=> !int_req_o);

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req_o && !int_we_o |-> !host_ready_o);

endmodule

bind iaw_window iaw_window_chk #(
    .DW        (DW),
    .AW        (AW),
    .REG_AW    (REG_AW),
    .IDLE_WORD (IDLE_WORD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake_i       (wake_i),
    .host_req_i   (host_req_i),
    .host_we_i    (host_we_i),
    .host_reg_i   (host_reg_i),
    .host_wdata_i (host_wdata_i),
    .host_ready_o (host_ready_o),
    .host_rvalid_o(host_rvalid_o),
    .host_rdata_o (host_rdata_o),
    .int_req_o    (int_req_o),
    .int_we_o     (int_we_o),
    .int_prph_o   (int_prph_o),
    .int_addr_o   (int_addr_o),
    .int_be_o     (int_be_o)
);

// File: tb/iaw_window_bench.sv
`timescale 1ns/1ps
module iaw_window_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wake = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  ridx = '0;
    logic [31:0] wdata = '0;
    logic        ready, rvalid;
    logic [31:0] rdata;
    logic        ireq, iwe, iprph;
    logic [31:0] iaddr, iwdata;
    logic [3:0]  ibe;
    logic [31:0] irdata;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] mem  [64];
    logic [31:0] preg [16];

    always #2.5 clk = ~clk;

    iaw_window u_iaw_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .wake_i       (wake),
        .host_req_i   (req),
        .host_we_i    (we),
        .host_reg_i   (ridx),
        .host_wdata_i (wdata),
        .host_ready_o (ready),
        .host_rvalid_o(rvalid),
        .host_rdata_o (rdata),
        .int_req_o    (ireq),
        .int_we_o     (iwe),
        .int_prph_o   (iprph),
        .int_addr_o   (iaddr),
        .int_be_o     (ibe),
        .int_wdata_o  (iwdata),
        .int_rdata_i  (irdata)
    );

    function automatic logic [31:0] mem_init(input int i);
        return 32'hC0DE_0000 + 32'(i) * 32'h11;
    endfunction

    function automatic logic [31:0] prph_init(input int i);
        return 32'h5000_0000 + 32'(i) * 32'h0101;
    endfunction

    // Internal memory and peripheral model, registered read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= mem_init(i);
            for (int i = 0; i < 16; i++) preg[i] <= prph_init(i);
            irdata <= '0;
        end else if (ireq) begin
            if (iprph) begin
                if (iwe) begin
                    for (int b = 0; b < 4; b++)
                        if (ibe[b]) preg[iaddr[3:0]][b*8 +: 8] <= iwdata[b*8 +: 8];
                end else begin
                    irdata <= preg[iaddr[3:0]];
                end
            end else begin
                if (iwe) begin
                    for (int b = 0; b < 4; b++)
                        if (ibe[b]) mem[iaddr[7:2]][b*8 +: 8] <= iwdata[b*8 +: 8];
                end else begin
                    irdata <= mem[iaddr[7:2]];
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input int r, input logic [31:0] v);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; we = 1'b1; ridx = 4'(r); wdata = v;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic host_rd(input int r, output logic [31:0] v);
        int n;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; we = 1'b0; ridx = 4'(r);
        @(negedge clk);
        req = 1'b0;
        n = 0;
        while (!rvalid && n < 10) begin
            @(negedge clk);
            n++;
        end
        v = rvalid ? rdata : 32'hDEAD_BEEF;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        chk("R1 ready", 32'(ready), 32'd1);
        chk("R1 rvalid", 32'(rvalid), 32'd0);
        chk("R1 int_req", 32'(ireq), 32'd0);
        host_rd(8, v); chk("R1 status", v, 32'd0);
        host_rd(0, v); chk("R1 read pointer", v, 32'd0);
    endtask

    task automatic t_mem_read();
        logic [31:0] v;
        host_wr(0, 32'h40);
        host_rd(1, v); chk("R2 first prefetched word", v, mem_init(16));
        host_rd(1, v); chk("R3 second word", v, mem_init(17));
        host_rd(1, v); chk("R3 third word", v, mem_init(18));
        host_rd(0, v); chk("R3 pointer advance", v, 32'h4C);
    endtask

    task automatic t_mem_write();
        logic [31:0] v;
        host_wr(2, 32'h80);
        host_wr(3, 32'h1234_5678);
        host_wr(3, 32'h9ABC_DEF0);
        wait_clks(3);
        chk("R4 first write", mem[32], 32'h1234_5678);
        chk("R4 second write", mem[33], 32'h9ABC_DEF0);
        host_rd(2, v); chk("R4 write pointer", v, 32'h88);
        host_rd(0, v); chk("R4 read pointer untouched", v, 32'h4C);
        host_wr(0, 32'h80);
        host_rd(1, v); chk("R2 read back written word", v, 32'h1234_5678);
    endtask

    task automatic t_prph();
        logic [31:0] v;
        host_wr(6, 32'h0000_0005);
        host_wr(7, 32'hAABB_CCDD);
        wait_clks(2);
        chk("R6 one byte write", preg[5], 32'h5000_05DD);
        host_wr(6, 32'h0100_0005);
        host_wr(7, 32'h1122_3344);
        wait_clks(2);
        chk("R6 two byte write", preg[5], 32'h5000_3344);
        host_wr(6, 32'h0300_0005);
        host_wr(7, 32'hCAFE_F00D);
        host_wr(7, 32'h0BAD_F00D);
        wait_clks(2);
        chk("R5 no offset advance", preg[5], 32'h0BAD_F00D);
        chk("R5 neighbour untouched", preg[6], prph_init(6));
        host_rd(6, v); chk("R5 write offset readback", v, 32'h0300_0005);
        host_wr(4, 32'h0100_0006);
        host_rd(5, v); chk("R7 two byte read", v, 32'h0000_0606);
        host_rd(4, v); chk("R5 read offset readback", v, 32'h0100_0006);
        host_wr(4, 32'h0300_0007);
        host_rd(5, v); chk("R7 full read", v, prph_init(7));
        host_wr(4, 32'h0000_0007);
        host_rd(5, v); chk("R7 one byte read", v, 32'h0000_0007);
    endtask

    task automatic t_sleep();
        logic [31:0] v;
        @(negedge clk); wake = 1'b0;
        host_rd(1, v); chk("R8 idle pattern mem", v, 32'hA5A5_A5A5);
        host_rd(5, v); chk("R8 idle pattern prph", v, 32'hA5A5_A5A5);
        host_rd(0, v); chk("R8 read pointer held", v, 32'h84);
        host_rd(8, v); chk("R9 sticky error set", v, 32'd1);
        host_wr(2, 32'h0);
        host_wr(3, 32'hFFFF_FFFF);
        host_wr(7, 32'hFFFF_FFFF);
        wait_clks(3);
        chk("R9 mem write dropped", mem[0], mem_init(0));
        chk("R9 prph write dropped", preg[5], 32'h0BAD_F00D);
        host_rd(2, v); chk("R9 write pointer held", v, 32'h0);
        host_wr(8, 32'h1);
        host_rd(8, v); chk("R9 error cleared", v, 32'd0);
        @(negedge clk); wake = 1'b1;
        host_rd(1, v); chk("R3 buffered word after wake", v, 32'h9ABC_DEF0);
        @(negedge clk); wake = 1'b0;
        host_wr(0, 32'h10);
        @(negedge clk); wake = 1'b1;
        host_rd(1, v); chk("R2 demand fetch after wake", v, mem_init(4));
        host_rd(0, v); chk("R3 pointer after demand", v, 32'h14);
        host_rd(8, v); chk("R9 no error when awake", v, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mem_read();
        t_mem_write();
        t_prph();
        t_sleep();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule